// File: doc/BRIEF.md
# Two-Way Set-Associative Read Cache

This block is a small read-only cache that sits between a requester and a slower line-oriented memory. It uses 12-bit byte addresses and 32-bit words. Storage is organised as two ways of two lines each, and each line holds two words, for eight words in total. An incoming address is split into a tag, a one-bit index and a word select. The two ways of the indexed set are compared with that tag in parallel. Either way can hold any memory line whose index matches, so two lines that collide on the index can be resident together.

On a hit, the matching way returns the word in the cycle after the request is accepted. On a miss, the block chooses a victim way. It then requests the whole line from the memory port, writes both returned beats into the victim, and answers with the requested word. The victim choice comes from an elaboration-time policy: least-recently-used, first-in-first-out, or pseudo-random from a free-running LFSR. An empty way is always filled before any resident line is evicted. Two counters record hits and misses.

All data-carrying interfaces use valid/ready handshakes:
- A transfer happens on a clock edge where both valid and ready are high.
- A source that raises valid keeps it high, with its payload stable, until that transfer.
- The request side takes one access at a time. `req_ready` stays low from acceptance until the response has been taken.

Top module: `twoway_rd_cache`

## Requirements
- R1: The address fields are: tag = addr[11:4], set index = addr[3], word select = addr[2]. The byte offset addr[1:0] has no effect on lookup or returned data.
- R2: After reset all lines are invalid. `req_ready` is 1, `rsp_valid` and `mem_req_valid` are 0, and both counters read 0. The first access to any set is a miss.
- R3: On a hit, `rsp_valid` rises in the cycle after acceptance with `rsp_hit`=1. `rsp_way` is the way holding the tag, and `rsp_data` is the addressed word. No memory request is made.
- R4: On a miss, exactly one memory request is issued with `mem_req_line` = {tag, index}. Two beats are then accepted while `mem_rsp_ready` is high, word 0 first and word 1 second. After the second beat the response carries `rsp_hit`=0, `rsp_way` = the filled way, and the addressed word.
- R5: Two lines with the same index and different tags stay resident together, one per way. At most one way ever matches.
- R6: On a miss, an invalid way is chosen before a valid one, and way 0 is chosen before way 1 when both are invalid.
- R7: With the LRU policy and both ways valid, the victim is the way of that set not touched by its most recent hit or fill.
- R8: With the FIFO policy and both ways valid, the victim is a per-set pointer. The pointer starts at way 0, moves to the other way after each fill of that set, and does not change on hits.
- R9: While `rsp_ready` is low, `rsp_valid`, `rsp_data`, `rsp_hit` and `rsp_way` are held. `req_ready` stays low until the response is taken. `mem_req_valid` and `mem_req_line` are held until `mem_req_ready`.
- R10: `hit_count` and `miss_count` each increase by one when a request that hits or misses is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 12 | Byte address of the read |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_data | output | 32 | Returned word |
| rsp_hit | output | 1 | 1 when the access hit |
| rsp_way | output | 1 | Way that supplied or received the line |
| mem_req_valid | output | 1 | Line fetch request present |
| mem_req_ready | input | 1 | Memory accepts the fetch request |
| mem_req_line | output | 9 | Line address {tag, index} |
| mem_rsp_valid | input | 1 | Memory beat present |
| mem_rsp_ready | output | 1 | Block accepts a memory beat |
| mem_rsp_data | input | 32 | Memory beat, word 0 then word 1 |
| hit_count | output | 16 | Accepted hits since reset |
| miss_count | output | 16 | Accepted misses since reset |

## Verification
The symptoms of a wrong internal state depend on which state is corrupted:
- A corrupted tag or valid bit turns an expected hit into a miss, or the reverse. This shows on `rsp_hit` one cycle after acceptance, and on the memory port as an extra or missing fetch.
- A wrong replacement bit or pointer evicts the wrong line. Nothing is visible at eviction time. It first appears when the evicted line is read again, as an unexpected miss naming the other way.
- A misplaced beat writes a word into the wrong slot. It shows only when that word is returned, either at the end of the fill or on a later hit.

For these reasons, the access sequences revisit evicted and surviving lines under both LRU and FIFO policies.

// File: rtl/tcw_pkg.sv
package tcw_pkg;
  typedef enum logic [1:0] {REPL_LRU, REPL_FIFO, REPL_RAND} repl_e;
  typedef enum logic [1:0] {ST_IDLE, ST_FREQ, ST_FDATA, ST_RESP} st_e;
endpackage

// File: rtl/tcw_lfsr.sv
module tcw_lfsr #(
  parameter int W = 8,
  parameter logic [W-1:0] TAPS = 8'hB8,
  parameter logic [W-1:0] SEED = 8'h5A
) (
  input  logic clk,
  input  logic rst_n,
  output logic bit_o
);
  logic [W-1:0] s_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s_q <= SEED;
    else        s_q <= {1'b0, s_q[W-1:1]} ^ (s_q[0] ? TAPS : '0);
  end

  assign bit_o = s_q[0];

  AST_LFSR_ALIVE: assert property (@(posedge clk) disable iff (!rst_n) s_q != '0); // R6
endmodule

// File: rtl/tcw_way_store.sv
module tcw_way_store #(
  parameter int TAG_W      = 8,
  parameter int WORD_W     = 32,
  parameter int SETS       = 2,
  parameter int LINE_WORDS = 2,
  localparam int IDX_W     = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int WSEL_W    = (LINE_WORDS > 1) ? $clog2(LINE_WORDS) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [IDX_W-1:0]             lk_idx,
  input  logic [TAG_W-1:0]             lk_tag,
  output logic                         lk_hit,
  output logic                         lk_valid,
  output logic [LINE_WORDS*WORD_W-1:0] lk_line,
  input  logic                         wr_en,
  input  logic [IDX_W-1:0]             wr_idx,
  input  logic [WSEL_W-1:0]            wr_wsel,
  input  logic [WORD_W-1:0]            wr_data,
  input  logic                         fin_en,
  input  logic [TAG_W-1:0]             fin_tag
);
  logic [TAG_W-1:0]  tag_q [SETS];
  logic [SETS-1:0]   vld_q;
  logic [WORD_W-1:0] dat_q [SETS][LINE_WORDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int s = 0; s < SETS; s++) tag_q[s] <= '0;
    end else if (fin_en) begin
      vld_q[wr_idx] <= 1'b1;
      tag_q[wr_idx] <= fin_tag;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) dat_q[wr_idx][wr_wsel] <= wr_data;
  end

  assign lk_valid = vld_q[lk_idx];
  assign lk_hit   = vld_q[lk_idx] && (tag_q[lk_idx] == lk_tag);

  for (genvar w = 0; w < LINE_WORDS; w++) begin : g_rd
    assign lk_line[w*WORD_W +: WORD_W] = dat_q[lk_idx][w];
  end

  AST_FIN_WITH_BEAT: assert property (@(posedge clk) disable iff (!rst_n) fin_en |-> wr_en); // R4
endmodule

// File: rtl/tcw_repl.sv
module tcw_repl #(
  parameter int SETS = 2,
  parameter tcw_pkg::repl_e POLICY = tcw_pkg::REPL_LRU,
  localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic             vld0,
  input  logic             vld1,
  input  logic             rnd,
  input  logic             upd_hit,
  input  logic             hit_way,
  input  logic [IDX_W-1:0] hit_idx,
  input  logic             upd_fill,
  input  logic             fill_way,
  input  logic [IDX_W-1:0] fill_idx,
  output logic             victim
);
  logic pol_pick;

  if (POLICY == tcw_pkg::REPL_LRU) begin : g_lru
    logic [SETS-1:0] old_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) old_q <= '0;
      else begin
        if (upd_hit)  old_q[hit_idx]  <= ~hit_way;
        if (upd_fill) old_q[fill_idx] <= ~fill_way;
      end
    end
    assign pol_pick = old_q[rd_idx];
  end else if (POLICY == tcw_pkg::REPL_FIFO) begin : g_fifo
    logic [SETS-1:0] ptr_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ptr_q <= '0;
      else if (upd_fill) ptr_q[fill_idx] <= ~fill_way;
    end
    assign pol_pick = ptr_q[rd_idx];
  end else begin : g_rand
    assign pol_pick = rnd;
  end

  always_comb begin
    if (!vld0)      victim = 1'b0;
    else if (!vld1) victim = 1'b1;
    else            victim = pol_pick;
  end

  AST_NO_DUAL_UPD: assert property (@(posedge clk) disable iff (!rst_n) !(upd_hit && upd_fill)); // R7
endmodule

// File: rtl/twoway_rd_cache.sv
module twoway_rd_cache #(
  parameter int ADDR_W     = 12,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 2,
  parameter int SETS       = 2,
  parameter int CNT_W      = 16,
  parameter tcw_pkg::repl_e POLICY = tcw_pkg::REPL_LRU,
  parameter logic [7:0] LFSR_SEED = 8'h5A,
  localparam int BYTE_W    = $clog2(WORD_W / 8),
  localparam int WSEL_W    = (LINE_WORDS > 1) ? $clog2(LINE_WORDS) : 1,
  localparam int IDX_W     = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int TAG_W     = ADDR_W - IDX_W - WSEL_W - BYTE_W,
  localparam int LINE_A_W  = TAG_W + IDX_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [ADDR_W-1:0]   req_addr,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [WORD_W-1:0]   rsp_data,
  output logic                rsp_hit,
  output logic                rsp_way,
  output logic                mem_req_valid,
  input  logic                mem_req_ready,
  output logic [LINE_A_W-1:0] mem_req_line,
  input  logic                mem_rsp_valid,
  output logic                mem_rsp_ready,
  input  logic [WORD_W-1:0]   mem_rsp_data,
  output logic [CNT_W-1:0]    hit_count,
  output logic [CNT_W-1:0]    miss_count
);
  import tcw_pkg::*;

  localparam int WAYS = 2;

  st_e st_q;
  logic [TAG_W-1:0]  a_tag_q;
  logic [IDX_W-1:0]  a_idx_q;
  logic [WSEL_W-1:0] a_wsel_q;
  logic [WSEL_W-1:0] beat_q;
  logic              vict_q;
  logic [WORD_W-1:0] data_q;
  logic              hit_q, way_q;

  logic [TAG_W-1:0]  req_tag;
  logic [IDX_W-1:0]  req_idx;
  logic [WSEL_W-1:0] req_wsel;
  logic              accept, any_hit, hway, victim, rnd_bit;
  logic              beat_fire, last_beat;
  logic [WAYS-1:0]   hit_w, vld_w;
  logic [LINE_WORDS*WORD_W-1:0] line_w [WAYS];

  assign req_tag  = req_addr[ADDR_W-1 -: TAG_W];
  assign req_idx  = req_addr[BYTE_W + WSEL_W +: IDX_W];
  assign req_wsel = req_addr[BYTE_W +: WSEL_W];

  assign req_ready     = (st_q == ST_IDLE);
  assign rsp_valid     = (st_q == ST_RESP);
  assign mem_req_valid = (st_q == ST_FREQ);
  assign mem_rsp_ready = (st_q == ST_FDATA);
  assign mem_req_line  = {a_tag_q, a_idx_q};
  assign rsp_data      = data_q;
  assign rsp_hit       = hit_q;
  assign rsp_way       = way_q;

  assign accept    = req_ready && req_valid;
  assign any_hit   = |hit_w;
  assign hway      = hit_w[1];
  assign beat_fire = mem_rsp_ready && mem_rsp_valid;
  assign last_beat = (beat_q == WSEL_W'(LINE_WORDS - 1));

  for (genvar g = 0; g < WAYS; g++) begin : g_way
    tcw_way_store #(
      .TAG_W(TAG_W), .WORD_W(WORD_W), .SETS(SETS), .LINE_WORDS(LINE_WORDS)
    ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .lk_idx   (req_idx),
      .lk_tag   (req_tag),
      .lk_hit   (hit_w[g]),
      .lk_valid (vld_w[g]),
      .lk_line  (line_w[g]),
      .wr_en    (beat_fire && (vict_q == 1'(g))),
      .wr_idx   (a_idx_q),
      .wr_wsel  (beat_q),
      .wr_data  (mem_rsp_data),
      .fin_en   (beat_fire && last_beat && (vict_q == 1'(g))),
      .fin_tag  (a_tag_q)
    );
  end

  tcw_lfsr #(.W(8), .TAPS(8'hB8), .SEED(LFSR_SEED)) u_lfsr (
    .clk   (clk),
    .rst_n (rst_n),
    .bit_o (rnd_bit)
  );

  tcw_repl #(.SETS(SETS), .POLICY(POLICY)) u_repl (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (req_idx),
    .vld0     (vld_w[0]),
    .vld1     (vld_w[1]),
    .rnd      (rnd_bit),
    .upd_hit  (accept && any_hit),
    .hit_way  (hway),
    .hit_idx  (req_idx),
    .upd_fill (beat_fire && last_beat),
    .fill_way (vict_q),
    .fill_idx (a_idx_q),
    .victim   (victim)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      a_tag_q    <= '0;
      a_idx_q    <= '0;
      a_wsel_q   <= '0;
      beat_q     <= '0;
      vict_q     <= 1'b0;
      data_q     <= '0;
      hit_q      <= 1'b0;
      way_q      <= 1'b0;
      hit_count  <= '0;
      miss_count <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (accept) begin
          a_tag_q  <= req_tag;
          a_idx_q  <= req_idx;
          a_wsel_q <= req_wsel;
          if (any_hit) begin
            data_q    <= line_w[hway][req_wsel*WORD_W +: WORD_W];
            hit_q     <= 1'b1;
            way_q     <= hway;
            hit_count <= hit_count + 1'b1;
            st_q      <= ST_RESP;
          end else begin
            vict_q     <= victim;
            miss_count <= miss_count + 1'b1;
            st_q       <= ST_FREQ;
          end
        end
        ST_FREQ: if (mem_req_ready) begin
          beat_q <= '0;
          st_q   <= ST_FDATA;
        end
        ST_FDATA: if (beat_fire) begin
          if (beat_q == a_wsel_q) data_q <= mem_rsp_data;
          beat_q <= beat_q + 1'b1;
          if (last_beat) begin
            hit_q <= 1'b0;
            way_q <= vict_q;
            st_q  <= ST_RESP;
          end
        end
        ST_RESP: if (rsp_ready) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  AST_ONE_WAY_MATCH: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(hit_w)); // R5
  AST_HIT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && any_hit) |=> (rsp_valid && rsp_hit && !mem_req_valid)); // R3
  AST_MISS_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !any_hit) |=> (mem_req_valid && mem_req_line == $past({req_tag, req_idx}))); // R4
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_hit) && $stable(rsp_way))); // R9
  AST_MREQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_line))); // R9
  AST_REQ_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |-> !req_ready); // R9
  AST_CNT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_count != $past(hit_count)) |-> (miss_count == $past(miss_count))); // R10
endmodule

// File: tb/twoway_rd_cache_tb.sv
module tcw_mem_model (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [8:0]  req_line,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [31:0] rsp_data,
  output int          fetches,
  output logic [8:0]  last_line
);
  logic busy, gap, beat;

  function automatic logic [31:0] word_of(input logic [8:0] ln, input logic w);
    return 32'hC0DE_0000 ^ {22'd0, ln, w};
  endfunction

  assign req_ready = !busy;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 0; gap <= 0; beat <= 0; rsp_valid <= 0; rsp_data <= '0;
      fetches <= 0; last_line <= '0;
    end else if (!busy) begin
      if (req_valid) begin
        busy <= 1; gap <= 1; beat <= 0; last_line <= req_line; fetches <= fetches + 1;
      end
    end else if (gap) begin
      gap <= 0; rsp_valid <= 1; rsp_data <= word_of(last_line, 1'b0);
    end else if (rsp_valid && rsp_ready) begin
      if (!beat) begin beat <= 1; rsp_data <= word_of(last_line, 1'b1); end
      else begin rsp_valid <= 0; busy <= 0; end
    end
  end
endmodule

module twoway_rd_cache_tb;
  import tcw_pkg::*;

  logic clk = 0;
  always #2 clk = ~clk;
  logic rst_n = 0;

  int errors = 0, checks = 0;
  bit done = 0;

  logic [11:0] req_addr = '0;
  logic rv_l = 0, rv_f = 0, rr_l = 1, rr_f = 1;
  logic rdy_l, rdy_f, rspv_l, rspv_f, hit_l, hit_f, way_l, way_f;
  logic [31:0] dat_l, dat_f, mdat_l, mdat_f;
  logic mqv_l, mqv_f, mqr_l, mqr_f, msv_l, msv_f, msr_l, msr_f;
  logic [8:0] mql_l, mql_f, last_l, last_f;
  logic [15:0] hc_l, mc_l, hc_f, mc_f;
  int fet_l, fet_f;

  twoway_rd_cache #(.POLICY(REPL_LRU)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(rv_l), .req_ready(rdy_l), .req_addr(req_addr),
    .rsp_valid(rspv_l), .rsp_ready(rr_l), .rsp_data(dat_l), .rsp_hit(hit_l), .rsp_way(way_l),
    .mem_req_valid(mqv_l), .mem_req_ready(mqr_l), .mem_req_line(mql_l),
    .mem_rsp_valid(msv_l), .mem_rsp_ready(msr_l), .mem_rsp_data(mdat_l),
    .hit_count(hc_l), .miss_count(mc_l));

  twoway_rd_cache #(.POLICY(REPL_FIFO)) u_dut_fifo (
    .clk(clk), .rst_n(rst_n), .req_valid(rv_f), .req_ready(rdy_f), .req_addr(req_addr),
    .rsp_valid(rspv_f), .rsp_ready(rr_f), .rsp_data(dat_f), .rsp_hit(hit_f), .rsp_way(way_f),
    .mem_req_valid(mqv_f), .mem_req_ready(mqr_f), .mem_req_line(mql_f),
    .mem_rsp_valid(msv_f), .mem_rsp_ready(msr_f), .mem_rsp_data(mdat_f),
    .hit_count(hc_f), .miss_count(mc_f));

  tcw_mem_model u_mem_l (.clk(clk), .rst_n(rst_n), .req_valid(mqv_l), .req_ready(mqr_l),
    .req_line(mql_l), .rsp_valid(msv_l), .rsp_ready(msr_l), .rsp_data(mdat_l),
    .fetches(fet_l), .last_line(last_l));
  tcw_mem_model u_mem_f (.clk(clk), .rst_n(rst_n), .req_valid(mqv_f), .req_ready(mqr_f),
    .req_line(mql_f), .rsp_valid(msv_f), .rsp_ready(msr_f), .rsp_data(mdat_f),
    .fetches(fet_f), .last_line(last_f));

  function automatic logic [31:0] exp_word(input logic [11:0] a);
    return 32'hC0DE_0000 ^ {22'd0, a[11:3], a[2]};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // {tag, idx, wsel, byte, hitL, wayL, hitF, wayF}
  localparam logic [15:0] VEC [10] = '{
    {8'h11, 1'b0, 1'b0, 2'd0, 4'b0000},
    {8'h11, 1'b0, 1'b1, 2'd0, 4'b1010},
    {8'h22, 1'b0, 1'b0, 2'd0, 4'b0101},
    {8'h11, 1'b0, 1'b0, 2'd0, 4'b1010},
    {8'h33, 1'b0, 1'b1, 2'd0, 4'b0100},
    {8'h22, 1'b0, 1'b0, 2'd0, 4'b0011},
    {8'h33, 1'b0, 1'b0, 2'd0, 4'b1110},
    {8'h55, 1'b1, 1'b1, 2'd0, 4'b0000},
    {8'h22, 1'b0, 1'b1, 2'd0, 4'b1011},
    {8'h55, 1'b1, 1'b0, 2'd3, 4'b1010}
  };

  task automatic run_pair(input logic [11:0] a,
                          output logic h_l, output logic w_l, output logic [31:0] d_l, output int lt_l,
                          output logic h_f, output logic w_f, output logic [31:0] d_f, output int lt_f);
    bit acc_l = 0, acc_f = 0, got_l = 0, got_f = 0, pl, pf;
    int n_l = 0, n_f = 0;
    req_addr = a; rv_l = 1; rv_f = 1; rr_l = 1; rr_f = 1;
    h_l = 0; w_l = 0; d_l = '0; h_f = 0; w_f = 0; d_f = '0; lt_l = -1; lt_f = -1;
    for (int n = 0; n < 80 && !(got_l && got_f); n++) begin
      @(negedge clk);
      if (acc_l) n_l++;
      if (acc_f) n_f++;
      if (acc_l && !got_l && rspv_l) begin got_l = 1; h_l = hit_l; w_l = way_l; d_l = dat_l; lt_l = n_l; end
      if (acc_f && !got_f && rspv_f) begin got_f = 1; h_f = hit_f; w_f = way_f; d_f = dat_f; lt_f = n_f; end
      pl = rv_l && rdy_l; pf = rv_f && rdy_f;
      @(posedge clk); #1;
      if (pl) begin rv_l = 0; acc_l = 1; end
      if (pf) begin rv_f = 0; acc_f = 1; end
    end
    if (!(got_l && got_f)) chk(0, "R3", "response timeout", 0, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic h_l, w_l, h_f, w_f;
    logic [31:0] d_l, d_f;
    int lt_l, lt_f, f0_l, f0_f;
    logic [11:0] a;

    repeat (3) @(posedge clk);
    @(negedge clk);
    // R2 reset state
    chk(rdy_l == 1 && rdy_f == 1, "R2", "req_ready after reset", rdy_l, 1);
    chk(rspv_l == 0 && rspv_f == 0, "R2", "rsp_valid after reset", rspv_l, 0);
    chk(mqv_l == 0 && mqv_f == 0, "R2", "mem_req_valid after reset", mqv_l, 0);
    chk(hc_l == 0 && mc_l == 0 && hc_f == 0 && mc_f == 0, "R2", "counters after reset", hc_l + mc_l, 0);
    rst_n = 1;
    @(posedge clk); #1;

    for (int i = 0; i < 10; i++) begin
      a = {VEC[i][15:8], VEC[i][7], VEC[i][6], VEC[i][5:4]};
      f0_l = fet_l; f0_f = fet_f;
      run_pair(a, h_l, w_l, d_l, lt_l, h_f, w_f, d_f, lt_f);
      // R1 R6 R7 hit/way for LRU; R8 for FIFO
      chk(h_l == VEC[i][3], "R7", $sformatf("LRU hit vec %0d", i), h_l, VEC[i][3]);
      chk(w_l == VEC[i][2], "R7", $sformatf("LRU way vec %0d", i), w_l, VEC[i][2]);
      chk(h_f == VEC[i][1], "R8", $sformatf("FIFO hit vec %0d", i), h_f, VEC[i][1]);
      chk(w_f == VEC[i][0], "R8", $sformatf("FIFO way vec %0d", i), w_f, VEC[i][0]);
      chk(d_l == exp_word(a), "R1", $sformatf("LRU data vec %0d", i), d_l, exp_word(a));
      chk(d_f == exp_word(a), "R4", $sformatf("FIFO data vec %0d", i), d_f, exp_word(a));
      if (VEC[i][3]) begin
        chk(lt_l == 1, "R3", "LRU hit latency", lt_l, 1);
        chk(fet_l == f0_l, "R3", "LRU hit fetched memory", fet_l, f0_l);
      end else begin
        chk(fet_l == f0_l + 1, "R4", "LRU miss fetch count", fet_l, f0_l + 1);
        chk(last_l == a[11:3], "R4", "LRU fetch line", last_l, a[11:3]);
      end
      if (VEC[i][1]) begin
        chk(lt_f == 1, "R3", "FIFO hit latency", lt_f, 1);
        chk(fet_f == f0_f, "R3", "FIFO hit fetched memory", fet_f, f0_f);
      end else begin
        chk(fet_f == f0_f + 1, "R4", "FIFO miss fetch count", fet_f, f0_f + 1);
      end
    end

    // R5: both tags of set 0 resident after vec 6..9 (LRU: 22 in way0, 33 in way1)
    // R9 back-pressure on a hit to tag 33 set 0 word 0
    a = {8'h33, 1'b0, 1'b0, 2'd0};
    req_addr = a; rr_l = 0; rv_l = 1;
    @(negedge clk);
    @(posedge clk); #1; rv_l = 0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(rspv_l == 1, "R9", "rsp_valid held", rspv_l, 1);
      chk(rdy_l == 0, "R9", "req_ready low while held", rdy_l, 0);
      chk(dat_l == exp_word(a) && hit_l == 1 && way_l == 1, "R5", "held hit on way1", dat_l, exp_word(a));
    end
    rr_l = 1;
    @(posedge clk); @(negedge clk);
    chk(rspv_l == 0 && rdy_l == 1, "R9", "release after rsp_ready", rspv_l, 0);

    // R10 counters
    chk(hc_l == 6 && mc_l == 5, "R10", "LRU counters", {hc_l, mc_l}, {16'd6, 16'd5});
    chk(hc_f == 6 && mc_f == 4, "R10", "FIFO counters", {hc_f, mc_f}, {16'd6, 16'd4});
    chk(fet_l == 5 && fet_f == 4, "R4", "total fetches", fet_l, 5);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule